// File: doc/BRIEF.md
# JTAG Debug Port Target

This block is the device end of a debug port that sits behind a JTAG TAP. The TAP controller stays outside; it hands the block an instruction load strobe with a 4-bit code, and one-cycle capture, shift and update strobes for the data register path, together with the serial input and output bits. The instruction picks one of several scan chains. One returns a fixed identification word. Two others carry 35-bit access requests, one aimed at the port's own registers and one aimed at an attached access port. The last is an abort chain. Any code that is not decoded selects a one-bit bypass chain.

Port-side registers are a bank-select register, a 32-bit upper-address register, a power control and status word, and a read buffer. The power request bits are mirrored into their acknowledge bits one cycle later. Reads are posted. A read request only loads the read buffer, and the value comes out during the capture phase of the next access scan. Access-port requests drive a simple bus with an address, write data and single-cycle read and write strobes. The transaction stays pending until the access port answers with a ready pulse, or until an abort clears it. While it is pending, access scans capture a WAIT acknowledge and their update is dropped.

Top module: `jdp_target`

## Requirements
- R1: After reset the instruction register holds the IDCODE code 1110, so a 32-bit scan with no instruction load returns the identification word. The read buffer is 0, and `ap_rd`, `ap_wr`, `ap_abort` and `tdo` are low.
- R2: With instruction 1110 the chain is 32 bits long. It captures version in bits 31:28, part number in 27:12, designer code in 11:1, and a 1 in bit 0. Bit 0 leaves first on `tdo`.
- R3: Any instruction code other than 1000, 1010, 1011 and 1110 selects a one-bit chain that captures 0. The bits shifted out are the bits shifted in, delayed by one shift.
- R4: Codes 1010 (port access) and 1011 (access-port access) select a 35-bit chain. Bit 0 is the read flag (1 = read), bits 2:1 are word offset A[3:2], and bits 34:3 are data. Capture loads the read buffer into bits 34:3 and an acknowledge into bits 2:0. A port read at offset 0x0, 0x4 or 0x8 loads the addressed value into the read buffer. A read at 0xC leaves the buffer unchanged.
- R5: A port write at offset 0x4 with bank 0 stores the system power request from bit 30 and the debug power request from bit 28. Each acknowledge (bit 31 and bit 29) follows its request one cycle later, so writing 0x50000000 reads back 0xF0000000.
- R6: Offset 0x8 is a 32-bit bank-select register whose bits 3:0 are the bank. Offset 0x4 reaches the power word in bank 0 and a 32-bit upper-address register in bank 5.
- R7: Writes at offset 0x0 and 0xC, and any access at offset 0x4 in a bank other than 0 or 5, change no state. Such reads return 0.
- R8: An accepted access-port scan drives `ap_rd` (read flag 1) or `ap_wr` (read flag 0) high for exactly the one cycle after the update. `ap_addr` is {upper-address, bank-select[31:4], A[3:2], 00} and `ap_wdata` is the scan data.
- R9: While an access-port transaction is pending, access scans capture WAIT (001) and their update has no effect. When idle they capture OK (010).
- R10: A ready pulse ends the pending transaction. For a read, `ap_rdata` at that edge is loaded into the read buffer.
- R11: Code 1000 selects a 35-bit chain that captures 0. An update with data bit 0 set (scan bit 3) pulses `ap_abort` for one cycle and clears the pending transaction. With bit 0 clear it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_load | input | 1 | Loads `ir_in` into the instruction register |
| ir_in | input | 4 | Instruction code |
| dr_capture | input | 1 | Capture strobe for the selected chain |
| dr_shift | input | 1 | Shift strobe, one bit per cycle |
| dr_update | input | 1 | Update strobe that applies the shifted request |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| ap_addr | output | 64 | Access-port address |
| ap_wdata | output | 32 | Access-port write data |
| ap_rd | output | 1 | Access-port read strobe |
| ap_wr | output | 1 | Access-port write strobe |
| ap_rdata | input | 32 | Access-port read data, valid with `ap_ready` |
| ap_ready | input | 1 | Access-port completion pulse |
| ap_abort | output | 1 | Abort pulse to the access port |

## Verification
Each result has a fixed lag after its stimulus. Access-port strobes and the abort pulse appear in the cycle right after the update cycle. A captured word is on `tdo` from the cycle after capture, one bit per shift. A posted read result only shows up in the capture of the next access scan, and power acknowledges lag requests by one cycle. The bench model sets its expected strobe values in the same falling-edge step that ends each update, and clears them one cycle later. A comparator samples all strobes, the address and the write data shortly after every falling edge. Captured scan words are compared against model state recorded before each scan started, so WAIT, dropped updates and posted results are all checked at the cycle where they become visible.

// File: rtl/jdp_pkg.sv
package jdp_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned IR_W   = 4;
  localparam int unsigned ACK_W  = 3;
  localparam int unsigned SCAN_W = WORD_W + ACK_W;
  localparam int unsigned APA_W  = 2 * WORD_W;
  localparam int unsigned HI_W   = WORD_W - 4;

  localparam logic [IR_W-1:0] IR_ABORT  = 4'b1000;
  localparam logic [IR_W-1:0] IR_DPREG  = 4'b1010;
  localparam logic [IR_W-1:0] IR_APREG  = 4'b1011;
  localparam logic [IR_W-1:0] IR_IDCODE = 4'b1110;

  localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;
  localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;

  localparam logic [3:0] BANK_PWR = 4'd0;
  localparam logic [3:0] BANK_UPA = 4'd5;

  localparam logic [1:0] OFS_ZERO   = 2'd0;
  localparam logic [1:0] OFS_BANKED = 2'd1;
  localparam logic [1:0] OFS_SELECT = 2'd2;
  localparam logic [1:0] OFS_RDBUF  = 2'd3;

  typedef enum logic [2:0] {
    CH_BYPASS,
    CH_IDCODE,
    CH_DPREG,
    CH_APREG,
    CH_ABORT
  } chain_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [1:0]        a;
    logic              rnw;
  } acc_req_t;

  function automatic int chain_len(input chain_e ch);
    case (ch)
      CH_BYPASS: return 1;
      CH_IDCODE: return int'(WORD_W);
      default:   return int'(SCAN_W);
    endcase
  endfunction

  function automatic logic [SCAN_W-1:0] shift_in(input logic [SCAN_W-1:0] v,
                                                 input logic b, input int len);
    logic [SCAN_W-1:0] r;
    r = v >> 1;
    for (int i = 0; i < int'(SCAN_W); i++) begin
      if (i == len - 1) r[i] = b;
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] make_idcode(input logic [3:0] ver,
                                                    input logic [15:0] part,
                                                    input logic [10:0] des);
    return {ver, part, des, 1'b1};
  endfunction

  function automatic logic [APA_W-1:0] ap_address(input logic [WORD_W-1:0] upper,
                                                  input logic [HI_W-1:0] sel_hi,
                                                  input logic [1:0] a);
    return {upper, sel_hi, a, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] pwr_word(input logic sys_req, input logic sys_ack,
                                                 input logic dbg_req, input logic dbg_ack);
    return {sys_ack, sys_req, dbg_ack, dbg_req, {(WORD_W-4){1'b0}}};
  endfunction

endpackage

// File: rtl/jdp_ir_dec.sv
module jdp_ir_dec
  import jdp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ir_load,
  input  logic [IR_W-1:0] ir_in,
  output chain_e          chain
);

  logic [IR_W-1:0] ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ir_q <= IR_IDCODE;
    else if (ir_load) ir_q <= ir_in;
  end

  always_comb begin
    case (ir_q)
      IR_IDCODE: chain = CH_IDCODE;
      IR_DPREG:  chain = CH_DPREG;
      IR_APREG:  chain = CH_APREG;
      IR_ABORT:  chain = CH_ABORT;
      default:   chain = CH_BYPASS;
    endcase
  end

endmodule

// File: rtl/jdp_scan_chain.sv
module jdp_scan_chain
  import jdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chain_e            chain,
  input  logic              dr_capture,
  input  logic              dr_shift,
  input  logic              dr_update,
  input  logic              tdi,
  input  logic [WORD_W-1:0] idcode,
  input  logic [WORD_W-1:0] rdbuff,
  input  logic              ap_busy,
  output logic              tdo,
  output logic              wait_q,
  output logic              dp_upd,
  output logic              ap_upd,
  output logic              abort_upd,
  output acc_req_t          req
);

  logic [SCAN_W-1:0] sr_q;
  logic              is_acc;

  assign is_acc = (chain == CH_DPREG) || (chain == CH_APREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      wait_q <= 1'b0;
    end else if (dr_capture) begin
      wait_q <= is_acc && ap_busy;
      case (chain)
        CH_IDCODE:         sr_q <= {{ACK_W{1'b0}}, idcode};
        CH_DPREG, CH_APREG: sr_q <= {rdbuff, (ap_busy ? ACK_WAIT : ACK_OK)};
        default:           sr_q <= '0;
      endcase
    end else if (dr_shift) begin
      sr_q <= shift_in(sr_q, tdi, chain_len(chain));
    end
  end

  assign tdo       = sr_q[0];
  assign req       = acc_req_t'(sr_q);
  assign dp_upd    = dr_update && (chain == CH_DPREG) && !wait_q;
  assign ap_upd    = dr_update && (chain == CH_APREG) && !wait_q;
  assign abort_upd = dr_update && (chain == CH_ABORT);

  a_r2_idcode_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_capture && chain == CH_IDCODE) |=> tdo);

  a_r3_bypass_capture_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_capture && chain == CH_BYPASS) |=> !tdo);

endmodule

// File: rtl/jdp_dp_regs.sv
module jdp_dp_regs
  import jdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_upd,
  input  acc_req_t          req,
  input  logic              ap_rd_done,
  input  logic [WORD_W-1:0] ap_rdata,
  output logic [HI_W-1:0]   sel_hi,
  output logic [WORD_W-1:0] upper_q,
  output logic [WORD_W-1:0] rdbuff_q
);

  logic [WORD_W-1:0] sel_q;
  logic              sys_req_q, sys_ack_q, dbg_req_q, dbg_ack_q;
  logic [3:0]        bank;
  logic [WORD_W-1:0] rd_val;
  logic              dp_wr, dp_rd;

  assign bank   = sel_q[3:0];
  assign sel_hi = sel_q[WORD_W-1:4];
  assign dp_wr  = dp_upd && !req.rnw;
  assign dp_rd  = dp_upd && req.rnw;

  always_comb begin
    case (req.a)
      OFS_BANKED: begin
        if (bank == BANK_PWR)      rd_val = pwr_word(sys_req_q, sys_ack_q, dbg_req_q, dbg_ack_q);
        else if (bank == BANK_UPA) rd_val = upper_q;
        else                       rd_val = '0;
      end
      OFS_SELECT: rd_val = sel_q;
      OFS_RDBUF:  rd_val = rdbuff_q;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      upper_q   <= '0;
      sys_req_q <= 1'b0;
      dbg_req_q <= 1'b0;
    end else if (dp_wr) begin
      if (req.a == OFS_SELECT) begin
        sel_q <= req.data;
      end else if (req.a == OFS_BANKED) begin
        if (bank == BANK_PWR) begin
          sys_req_q <= req.data[30];
          dbg_req_q <= req.data[28];
        end else if (bank == BANK_UPA) begin
          upper_q <= req.data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_ack_q <= 1'b0;
      dbg_ack_q <= 1'b0;
    end else begin
      sys_ack_q <= sys_req_q;
      dbg_ack_q <= dbg_req_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdbuff_q <= '0;
    else if (dp_rd)      rdbuff_q <= rd_val;
    else if (ap_rd_done) rdbuff_q <= ap_rdata;
  end

  a_r5_dbg_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_q && $past(dbg_req_q)) |-> dbg_ack_q);

  a_r5_sys_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_req_q && !$past(sys_req_q)) |-> !sys_ack_q);

endmodule

// File: rtl/jdp_ap_port.sv
module jdp_ap_port
  import jdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ap_upd,
  input  logic              abort_upd,
  input  acc_req_t          req,
  input  logic [HI_W-1:0]   sel_hi,
  input  logic [WORD_W-1:0] upper,
  input  logic              ap_ready,
  output logic [APA_W-1:0]  ap_addr,
  output logic [WORD_W-1:0] ap_wdata,
  output logic              ap_rd,
  output logic              ap_wr,
  output logic              ap_abort,
  output logic              pending,
  output logic              rd_done
);

  logic is_rd_q;
  logic abort_go;

  assign abort_go = abort_upd && req.data[0];
  assign rd_done  = pending && ap_ready && is_rd_q && !abort_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_addr  <= '0;
      ap_wdata <= '0;
      ap_rd    <= 1'b0;
      ap_wr    <= 1'b0;
      ap_abort <= 1'b0;
      pending  <= 1'b0;
      is_rd_q  <= 1'b0;
    end else begin
      ap_rd    <= 1'b0;
      ap_wr    <= 1'b0;
      ap_abort <= 1'b0;
      if (abort_go) begin
        ap_abort <= 1'b1;
        pending  <= 1'b0;
      end else if (ap_upd) begin
        ap_addr  <= ap_address(upper, sel_hi, req.a);
        ap_wdata <= req.data;
        ap_rd    <= req.rnw;
        ap_wr    <= !req.rnw;
        is_rd_q  <= req.rnw;
        pending  <= 1'b1;
      end else if (pending && ap_ready) begin
        pending  <= 1'b0;
      end
    end
  end

  a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_rd || ap_wr) |=> !(ap_rd || ap_wr));

  a_r8_strobe_marks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_rd || ap_wr) |-> pending);

  a_r11_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ap_abort |-> !pending);

endmodule

// File: rtl/jdp_target.sv
module jdp_target
  import jdp_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION  = 4'h1,
  parameter logic [15:0] ID_PARTNO   = 16'h0012,
  parameter logic [10:0] ID_DESIGNER = 11'h0A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_load,
  input  logic [IR_W-1:0]   ir_in,
  input  logic              dr_capture,
  input  logic              dr_shift,
  input  logic              dr_update,
  input  logic              tdi,
  output logic              tdo,
  output logic [APA_W-1:0]  ap_addr,
  output logic [WORD_W-1:0] ap_wdata,
  output logic              ap_rd,
  output logic              ap_wr,
  input  logic [WORD_W-1:0] ap_rdata,
  input  logic              ap_ready,
  output logic              ap_abort
);

  localparam logic [WORD_W-1:0] IDCODE_VAL = make_idcode(ID_VERSION, ID_PARTNO, ID_DESIGNER);

  chain_e            chain;
  acc_req_t          req;
  logic              wait_q, dp_upd, ap_upd, abort_upd;
  logic              pending, rd_done;
  logic [HI_W-1:0]   sel_hi;
  logic [WORD_W-1:0] upper, rdbuff;

  jdp_ir_dec u_ir (
    .clk     (clk),
    .rst_n   (rst_n),
    .ir_load (ir_load),
    .ir_in   (ir_in),
    .chain   (chain)
  );

  jdp_scan_chain u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .chain      (chain),
    .dr_capture (dr_capture),
    .dr_shift   (dr_shift),
    .dr_update  (dr_update),
    .tdi        (tdi),
    .idcode     (IDCODE_VAL),
    .rdbuff     (rdbuff),
    .ap_busy    (pending),
    .tdo        (tdo),
    .wait_q     (wait_q),
    .dp_upd     (dp_upd),
    .ap_upd     (ap_upd),
    .abort_upd  (abort_upd),
    .req        (req)
  );

  jdp_dp_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .dp_upd     (dp_upd),
    .req        (req),
    .ap_rd_done (rd_done),
    .ap_rdata   (ap_rdata),
    .sel_hi     (sel_hi),
    .upper_q    (upper),
    .rdbuff_q   (rdbuff)
  );

  jdp_ap_port u_ap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ap_upd    (ap_upd),
    .abort_upd (abort_upd),
    .req       (req),
    .sel_hi    (sel_hi),
    .upper     (upper),
    .ap_ready  (ap_ready),
    .ap_addr   (ap_addr),
    .ap_wdata  (ap_wdata),
    .ap_rd     (ap_rd),
    .ap_wr     (ap_wr),
    .ap_abort  (ap_abort),
    .pending   (pending),
    .rd_done   (rd_done)
  );

  a_r9_wait_blocks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_update && wait_q) |=> !(ap_rd || ap_wr));

  a_r10_done_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_ready && !pending) |=> $stable(rdbuff) || $past(dp_upd));

endmodule

// File: tb/jdp_target_bench.sv
module jdp_target_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_load = 1'b0;
  logic [3:0]  ir_in = 4'h0;
  logic        dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic [63:0] ap_addr;
  logic [31:0] ap_wdata;
  logic        ap_rd, ap_wr, ap_abort;
  logic [31:0] ap_rdata = 32'h0;
  logic        ap_ready = 1'b0;

  always #5 clk = ~clk;

  jdp_target u_jdp_target (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_in(ir_in),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .tdi(tdi), .tdo(tdo), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
    .ap_rd(ap_rd), .ap_wr(ap_wr), .ap_rdata(ap_rdata), .ap_ready(ap_ready),
    .ap_abort(ap_abort)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  // behavioural model of the visible state
  logic [31:0] m_sel = 0, m_upper = 0, m_rdbuff = 0;
  bit          m_sys = 0, m_dbg = 0, m_pending = 0, m_pend_rd = 0;
  logic        exp_rd = 0, exp_wr = 0, exp_ab = 0;
  logic [63:0] exp_addr = 0;
  logic [31:0] exp_wdata = 0;

  localparam logic [31:0] EXP_ID = (32'h1 << 28) | (32'h12 << 12) | (32'h0A5 << 1) | 32'h1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // per-cycle comparison of the access-port side against the model
  always begin
    @(negedge clk);
    #1;
    cyc++;
    if (rst_n && !done) begin
      check("R8 R9 R11 strobes per cycle", {61'b0, ap_rd, ap_wr, ap_abort},
            {61'b0, exp_rd, exp_wr, exp_ab});
      if (exp_rd || exp_wr) check("R8 address", ap_addr, exp_addr);
      if (exp_wr) check("R8 write data", {32'b0, ap_wdata}, {32'b0, exp_wdata});
    end
    if (cyc > 20000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      done = 1'b1;
      finish_run();
    end
  end

  task automatic ir_set(input logic [3:0] c);
    @(negedge clk); ir_load = 1'b1; ir_in = c;
    @(negedge clk); ir_load = 1'b0;
  endtask

  task automatic scan_dr(input logic [34:0] din, input int n, output logic [34:0] dout);
    dout = '0;
    @(negedge clk); dr_capture = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dr_capture = 1'b0; dr_shift = 1'b1; tdi = din[i];
      dout[i] = tdo;
    end
    @(negedge clk); dr_shift = 1'b0; dr_update = 1'b1;
    @(negedge clk); dr_update = 1'b0;
  endtask

  task automatic model_dp(input bit rnw, input logic [1:0] a, input logic [31:0] data);
    case (a)
      2'd0: if (rnw) m_rdbuff = 0;
      2'd1: begin
        if (m_sel[3:0] == 4'd0) begin
          if (rnw) m_rdbuff = (m_sys ? 32'hC000_0000 : 32'h0) | (m_dbg ? 32'h3000_0000 : 32'h0);
          else begin m_sys = data[30]; m_dbg = data[28]; end
        end else if (m_sel[3:0] == 4'd5) begin
          if (rnw) m_rdbuff = m_upper; else m_upper = data;
        end else if (rnw) m_rdbuff = 0;
      end
      2'd2: if (rnw) m_rdbuff = m_sel; else m_sel = data;
      default: ;
    endcase
  endtask

  task automatic acc(input string tag, input bit ap, input bit rnw,
                     input logic [1:0] a, input logic [31:0] data);
    logic [34:0] dout;
    logic [34:0] expv;
    bit busy;
    busy = m_pending;
    expv = {m_rdbuff, (busy ? 3'b001 : 3'b010)};
    ir_set(ap ? 4'b1011 : 4'b1010);
    scan_dr({data, a, rnw}, 35, dout);
    check(tag, {29'b0, dout}, {29'b0, expv});
    if (!busy) begin
      if (ap) begin
        m_pending = 1; m_pend_rd = rnw;
        exp_addr  = {m_upper, m_sel[31:4], a, 2'b00};
        exp_wdata = data;
        exp_rd = rnw; exp_wr = !rnw;
        @(negedge clk); exp_rd = 1'b0; exp_wr = 1'b0;
      end else begin
        model_dp(rnw, a, data);
      end
    end
  endtask

  task automatic abort_scan(input bit b);
    logic [34:0] dout;
    ir_set(4'b1000);
    scan_dr({31'b0, b, 3'b000}, 35, dout);
    check("R11 abort chain captures 0", {29'b0, dout}, 64'h0);
    if (b) begin
      m_pending = 0;
      exp_ab = 1'b1;
      @(negedge clk); exp_ab = 1'b0;
    end
  endtask

  task automatic ap_reply(input logic [31:0] d);
    @(negedge clk); ap_ready = 1'b1; ap_rdata = d;
    @(negedge clk); ap_ready = 1'b0;
    if (m_pending) begin
      m_pending = 0;
      if (m_pend_rd) m_rdbuff = d;
    end
  endtask

  initial begin
    logic [34:0] d;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {60'b0, ap_rd, ap_wr, ap_abort, tdo}, 64'h0);
    rst_n = 1'b1;

    scan_dr(35'h0, 32, d);
    check("R1 default instruction is IDCODE", {32'b0, d[31:0]}, {32'b0, EXP_ID});
    acc("R1 read buffer resets to 0", 0, 1, 2'd3, 32'h0);

    ir_set(4'b1110);
    scan_dr(35'h0, 32, d);
    check("R2 identification word", {32'b0, d[31:0]}, {32'b0, EXP_ID});

    ir_set(4'b1111);
    scan_dr(35'hA5, 8, d);
    check("R3 bypass 1111", {56'b0, d[7:0]}, {56'b0, 8'h4A});
    ir_set(4'b0000);
    scan_dr(35'h3C, 8, d);
    check("R3 bypass 0000", {56'b0, d[7:0]}, {56'b0, 8'h78});

    acc("R5 power request write", 0, 0, 2'd1, 32'h5000_0000);
    acc("R4 read request of power word", 0, 1, 2'd1, 32'h0);
    acc("R4 R5 posted power word", 0, 1, 2'd3, 32'h0);
    acc("R4 buffer read leaves buffer", 0, 1, 2'd3, 32'h0);

    acc("R6 select bank 5", 0, 0, 2'd2, 32'h0C20_0D05);
    acc("R6 upper address write", 0, 0, 2'd1, 32'h0000_0004);
    acc("R6 upper address read", 0, 1, 2'd1, 32'h0);
    acc("R6 select read", 0, 1, 2'd2, 32'h0);
    acc("R6 select value returned", 0, 1, 2'd3, 32'h0);

    acc("R7 select bank 3", 0, 0, 2'd2, 32'h0000_0003);
    acc("R7 write in unused bank", 0, 0, 2'd1, 32'hFFFF_FFFF);
    acc("R7 read in unused bank", 0, 1, 2'd1, 32'h0);
    acc("R7 write to buffer offset", 0, 0, 2'd3, 32'h1234_5678);
    acc("R7 write to offset 0", 0, 0, 2'd0, 32'h8765_4321);
    acc("R7 read offset 0", 0, 1, 2'd0, 32'h0);
    acc("R7 back to bank 0", 0, 0, 2'd2, 32'h1234_5670);
    acc("R7 power word intact", 0, 1, 2'd1, 32'h0);
    acc("R7 select read", 0, 1, 2'd2, 32'h0);
    acc("R6 R7 select value", 0, 1, 2'd3, 32'h0);

    acc("R8 access-port write", 1, 0, 2'd2, 32'hDEAD_BEEF);
    acc("R9 port access while pending", 0, 1, 2'd2, 32'h0);
    acc("R9 access-port access while pending", 1, 1, 2'd0, 32'h0);
    ap_reply(32'h0);
    acc("R9 OK after ready", 0, 1, 2'd3, 32'h0);

    acc("R8 R10 access-port read", 1, 1, 2'd1, 32'h0);
    ap_reply(32'hCAFE_0001);
    acc("R10 read result in buffer", 0, 1, 2'd3, 32'h0);

    acc("R11 read left unanswered", 1, 1, 2'd0, 32'h0);
    abort_scan(1'b0);
    acc("R11 clear abort bit has no effect", 0, 1, 2'd3, 32'h0);
    abort_scan(1'b1);
    acc("R11 idle after abort", 0, 1, 2'd3, 32'h0);

    acc("R5 clear requests", 0, 0, 2'd1, 32'h0);
    acc("R5 read power word", 0, 1, 2'd1, 32'h0);
    acc("R5 acks dropped", 0, 1, 2'd3, 32'h0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule